// File: doc/BRIEF.md
# PRBS Pattern Generator and Checker

This block is a built-in self-test engine for a serial link data path. On the transmit side it produces a pseudo-random bit sequence, packed into parallel words of 8, 10, 16 or 20 bits. On the receive side a checker watches the incoming words. It waits for a fixed marker pattern and then loads its own sequence register from that word. From then on it predicts every following word and flags each one that differs.

A 2-bit mode input picks both the polynomial and the word width. The two narrow widths each use one polynomial. Each wide width is built from two consecutive narrow chunks. One mode serves the whole block at a time. Changing the mode restarts both halves.

Top module: `prbs_bist`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `tx_word` is 0, `locked` is 0, `err_pulse` is 0 and `err_count` is 0.
- R2: Mode codes 0 (8-bit word) and 2 (16-bit word) follow the bit recurrence b[k] = b[k-8] ^ b[k-7] ^ b[k-5] ^ b[k-3], which is the polynomial x^8+x^7+x^5+x^3+1 with period 255. Generation starts from a history in which the most recent bit is 1 and all earlier bits are 0.
- R3: Mode codes 1 (10-bit word) and 3 (20-bit word) follow b[k] = b[k-10] ^ b[k-7], which is the polynomial x^10+x^7+1 with period 1023. Generation starts from the same history as in R2.
- R4: Each clock edge with `gen_en` high loads the next W bits of the sequence into `tx_word`. The earliest of those bits sits in bit W-1, bits above W-1 are 0, and a 16-bit or 20-bit word holds two consecutive narrow chunks.
- R5: With `gen_en` low, `tx_word` holds its value and the sequence position does not advance.
- R6: While unlocked, the checker locks on a received word whose lowest narrow chunk equals the marker. The marker is 8'b10000000 in modes 0 and 2, and ten ones in modes 1 and 3. `locked` rises the cycle after that word.
- R7: While locked, each received word that differs from the predicted word raises `err_pulse` for the following cycle and adds 1 to `err_count`. The prediction advances anyway, so an isolated error does not cause further errors.
- R8: A run of 4 consecutive erroneous words clears `locked` in the cycle after the fourth one.
- R9: `err_count` saturates at 16'hFFFF and stays there while errors continue.
- R10: Received bits above the active word width are ignored.
- R11: A change of `mode` clears `locked` and `tx_word` in the next cycle, and the generator restarts from the R2 history.
- R12: The narrow sequence register never holds all zeros. An all-zero value is replaced by the start value before it is stepped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Width and polynomial select (0: 8, 1: 10, 2: 16, 3: 20 bits) |
| gen_en | input | 1 | Advance the generator by one word per cycle |
| rx_word | input | 20 | Received word, checked every cycle |
| tx_word | output | 20 | Generated word |
| locked | output | 1 | Checker is aligned and comparing |
| err_pulse | output | 1 | One-cycle flag for a mismatching word |
| err_count | output | 16 | Saturating count of mismatching words |

## Verification
The hardest state to reach is a saturated error counter while the checker is still locked. Four consecutive errors drop lock, so errors alone can never push the counter to its limit. The bench loops the generator back into the checker and flips a bit in three words out of every four for about 88,000 words. The fourth word stays clean, which resets the error run. This drives the count past 65535 with lock held, so the bench can confirm that the count stops at the limit and that pulses keep coming. Reaching lock also depends on the marker appearing in the lowest chunk. The bench therefore runs each mode long enough to cover a full sequence period.

// File: rtl/prbs_bist.sv
module prbs_bist #(
  parameter int CNT_W      = 16,
  parameter int DROP_AFTER = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode,
  input  logic        gen_en,
  input  logic [19:0] rx_word,
  output logic [19:0] tx_word,
  output logic        locked,
  output logic        err_pulse,
  output logic [CNT_W-1:0] err_count
);
  localparam int RUN_W = $clog2(DROP_AFTER + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [9:0] SEED = 10'd1;

  function automatic logic [9:0] fix(input logic [9:0] s, input logic t);
    if (t ? (s == 10'd0) : (s[7:0] == 8'd0)) return SEED;
    return s;
  endfunction

  function automatic logic [9:0] adv(input logic [9:0] s, input logic t);
    logic [9:0] r;
    r = s;
    for (int i = 0; i < 10; i++)
      if (t || i < 8)
        r = t ? {r[8:0], r[9] ^ r[6]} : {2'b00, r[6:0], r[7] ^ r[6] ^ r[4] ^ r[2]};
    return r;
  endfunction

  function automatic logic [19:0] pack(input logic [9:0] a, input logic [9:0] b, input logic [1:0] m);
    case (m)
      2'd0:    return {12'd0, a[7:0]};
      2'd1:    return {10'd0, a};
      2'd2:    return {4'd0, a[7:0], b[7:0]};
      default: return {a, b};
    endcase
  endfunction

  logic ten, wide, mode_chg;
  logic [1:0] mode_q;
  assign ten      = mode[0];
  assign wide     = mode[1];
  assign mode_chg = (mode != mode_q);

  logic [9:0]  gen_s, g1, g2;
  logic [19:0] gen_word;
  assign g1       = adv(fix(gen_s, ten), ten);
  assign g2       = adv(g1, ten);
  assign gen_word = pack(g1, g2, mode);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q  <= mode;
      gen_s   <= SEED;
      tx_word <= '0;
    end else begin
      mode_q <= mode;
      if (mode_chg) begin
        gen_s   <= SEED;
        tx_word <= '0;
      end else if (gen_en) begin
        gen_s   <= wide ? g2 : g1;
        tx_word <= gen_word;
      end
    end

  logic [9:0]  chk_s, c1, c2, rx_low;
  logic [19:0] exp_word, mask;
  logic        mismatch, marker_hit;
  logic [RUN_W-1:0] bad_run;

  assign c1       = adv(fix(chk_s, ten), ten);
  assign c2       = adv(c1, ten);
  assign exp_word = pack(c1, c2, mode);
  assign mask     = mode == 2'd0 ? 20'h000FF : mode == 2'd1 ? 20'h003FF :
                    mode == 2'd2 ? 20'h0FFFF : 20'hFFFFF;
  assign mismatch = ((rx_word ^ exp_word) & mask) != 20'd0;
  assign rx_low   = ten ? rx_word[9:0] : {2'b00, rx_word[7:0]};
  assign marker_hit = ten ? (rx_word[9:0] == 10'h3FF) : (rx_word[7:0] == 8'h80);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      locked    <= 1'b0;
      chk_s     <= SEED;
      bad_run   <= '0;
      err_pulse <= 1'b0;
      err_count <= '0;
    end else begin
      err_pulse <= 1'b0;
      if (mode_chg) begin
        locked  <= 1'b0;
        bad_run <= '0;
      end else if (!locked) begin
        if (marker_hit) begin
          locked  <= 1'b1;
          chk_s   <= rx_low;
          bad_run <= '0;
        end
      end else begin
        chk_s <= wide ? c2 : c1;
        if (mismatch) begin
          err_pulse <= 1'b1;
          if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
          if (bad_run == RUN_W'(DROP_AFTER - 1)) begin
            locked  <= 1'b0;
            bad_run <= '0;
          end else begin
            bad_run <= bad_run + 1'b1;
          end
        end else begin
          bad_run <= '0;
        end
      end
    end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !mode_chg) |=> $stable(tx_word));
  p_lock_marker_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(marker_hit));
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_count == $past(err_count) + 1'b1 || err_count == CNT_MAX));
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> $stable(err_count));
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !mode_chg && mismatch && bad_run == RUN_W'(DROP_AFTER - 1)) |=> !locked);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX) |=> (err_count == CNT_MAX));
  p_mode_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (!locked && tx_word == 20'd0));
  p_nonzero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_chg |-> (ten ? gen_s != 10'd0 : gen_s[7:0] != 8'd0));
endmodule

// File: tb/test_prbs_bist.sv
module test_prbs_bist;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic gen_en = 1'b0;
  logic [19:0] inj = 20'd0;
  logic [19:0] rx_word, tx_word;
  logic locked, err_pulse;
  logic [15:0] err_count;

  always #5 clk = ~clk;
  assign rx_word = tx_word ^ inj;

  prbs_bist i_prbs_bist (.clk(clk), .rst_n(rst_n), .mode(mode), .gen_en(gen_en),
    .rx_word(rx_word), .tx_word(tx_word), .locked(locked),
    .err_pulse(err_pulse), .err_count(err_count));

  int n_chk = 0, n_err = 0;
  logic [9:0] h;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] model_word();
    logic [19:0] w;
    int wd;
    logic nb;
    w = '0;
    wd = mode == 2'd0 ? 8 : mode == 2'd1 ? 10 : mode == 2'd2 ? 16 : 20;
    for (int i = 0; i < wd; i++) begin
      nb = mode[0] ? (h[9] ^ h[6]) : (h[7] ^ h[4 + 3] ^ 1'b0) ^ h[6] ^ h[4] ^ h[2] ^ h[7];
      h = {h[8:0], nb};
      w = {w[18:0], nb};
    end
    return w;
  endfunction

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; mode = m; gen_en = 1'b0; inj = '0; h = 10'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_word == 0 && !locked && !err_pulse && err_count == 0, "R1 reset state",
        {tx_word[15:0], err_count}, 32'd0);
  endtask

  task automatic run_to_lock(input string tag);
    logic [19:0] prev, expw;
    int bad;
    bit lk, mk;
    bad = 0; lk = 0; mk = 1;
    gen_en = 1'b1;
    prev = rx_word;
    for (int c = 0; c < 2200 && !lk; c++) begin
      @(negedge clk);
      expw = model_word();
      if (tx_word != expw) bad++;
      if (locked) begin
        lk = 1;
        mk = mode[0] ? (prev[9:0] == 10'h3FF) : (prev[7:0] == 8'h80);
      end
      prev = rx_word;
    end
    chk(bad == 0, {tag, " R2 R3 R4 generated words"}, bad, 0);
    chk(lk, {tag, " R6 lock reached"}, lk, 1);
    chk(mk, {tag, " R6 lock follows marker"}, prev, 0);
  endtask

  typedef struct packed {
    logic [1:0]  m;
    logic [19:0] mask;
    logic [3:0]  n;
    logic [3:0]  cnt;
    logic        lk;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 20'h00001, 4'd1, 4'd1, 1'b1},
    '{2'd1, 20'h00200, 4'd2, 4'd2, 1'b1},
    '{2'd2, 20'h08000, 4'd3, 4'd3, 1'b1},
    '{2'd3, 20'h80000, 4'd4, 4'd4, 1'b0},
    '{2'd0, 20'hFFF00, 4'd4, 4'd0, 1'b1},
    '{2'd1, 20'hFFC00, 4'd3, 4'd0, 1'b1}
  };

  initial begin
    #(10 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [19:0] held, expw;
    for (int v = 0; v < 6; v++) begin
      do_reset(VECS[v].m);
      run_to_lock($sformatf("vec%0d", v));
      repeat (3) @(negedge clk);
      for (int k = 0; k < VECS[v].n; k++) begin
        inj = VECS[v].mask;
        @(negedge clk);
        chk(err_pulse == (VECS[v].cnt != 0), "R7 R10 error pulse per word", err_pulse, VECS[v].cnt != 0);
      end
      inj = '0;
      chk(err_count == VECS[v].cnt, "R7 R10 error count", err_count, VECS[v].cnt);
      chk(locked == VECS[v].lk, "R8 lock after error run", locked, VECS[v].lk);
      if (VECS[v].lk) begin
        repeat (5) @(negedge clk);
        chk(err_count == VECS[v].cnt && locked && !err_pulse, "R7 no follow-on errors",
            err_count, VECS[v].cnt);
      end
    end

    do_reset(2'd3);
    repeat (3) @(negedge clk);
    chk(tx_word == 0, "R5 idle generator stays at reset word", tx_word, 0);
    gen_en = 1'b1;
    repeat (2) begin
      @(negedge clk);
      expw = model_word();
    end
    chk(tx_word == expw, "R4 20-bit word", tx_word, expw);
    gen_en = 1'b0;
    held = tx_word;
    repeat (4) @(negedge clk);
    chk(tx_word == held, "R5 hold while disabled", tx_word, held);
    gen_en = 1'b1;
    @(negedge clk);
    expw = model_word();
    chk(tx_word == expw, "R5 resumes without skipping", tx_word, expw);

    do_reset(2'd0);
    run_to_lock("mode change");
    mode = 2'd1;
    @(negedge clk);
    chk(!locked && tx_word == 0, "R11 mode change clears lock and word", {locked, tx_word}, 0);
    h = 10'd1;
    @(negedge clk);
    expw = model_word();
    chk(tx_word == expw, "R11 restart from start value", tx_word, expw);

    do_reset(2'd0);
    run_to_lock("saturation");
    for (int i = 0; i < 88000; i++) begin
      inj = (i % 4 != 3) ? 20'h00001 : 20'd0;
      @(negedge clk);
      if (i == 87998)
        chk(err_pulse && err_count == 16'hFFFF, "R9 pulse at saturated count", err_count, 16'hFFFF);
    end
    inj = '0;
    chk(err_count == 16'hFFFF, "R9 count saturates", err_count, 16'hFFFF);
    chk(locked, "R8 lock kept when runs stay short", locked, 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule